// File: doc/BRIEF.md
# Sixteen-Bit Instruction Decoder with Control Strobes

This block turns one 16-bit instruction word into the information that an execution stage needs. It splits the word into its opcode, its register indices and its constant field. The constant is widened to 16 bits with sign or zero extension, depending on the instruction. The block also drives the control strobes for that instruction: the ALU operation, the register write enable and destination, memory and I/O read and write, the branch class, and four system flags. The decoder has no clock and no state. Its outputs follow the instruction input in the same cycle.

The ISA has eight general registers and a 5-bit opcode in the top bits of the word. Each opcode belongs to one of four fixed layouts:
- No operands.
- One register and an 8-bit constant.
- Two registers and a 5-bit constant.
- Three registers.

The field that a layout does not carry is reported as zero. Multiply and divide also write a second result into R0. A separate strobe marks that second write. An illegal-opcode output exists and forces every write strobe low. With the present 32-entry map, every opcode value is defined, so that output never rises.

Top module: `instr_decoder`

## Requirements
- R1: The opcode is bits 15..11. The first register index is bits 10..8, the second is bits 7..5 and the third is bits 4..2. Each index is driven only when the instruction layout carries that register and is 0 otherwise.
- R2: The layout code is 0 for opcodes 21, 26, 27, 30 and 31. It is 1 for opcodes 7, 16 to 20 and 23 to 25. It is 2 for opcodes 1, 3, 6, 9, 11 to 15, 22, 28 and 29. It is 3 for opcodes 0, 2, 4, 5, 8 and 10.
- R3: The immediate output is set by opcode as follows:
  - Sign-extended 8-bit constant (bits 7..0): opcodes 7 and 16 to 20.
  - Zero-extended 8-bit constant (bits 7..0): opcodes 24 and 25.
  - Sign-extended 5-bit constant (bits 4..0): opcodes 1, 3, 28 and 29.
  - Zero-extended 5-bit constant (bits 4..0): opcodes 9, 11, 12, 13 and 15.
  - 0: all other opcodes.
- R4: The register write enable is high, with the destination equal to the first register index, for these opcodes: 0 to 15, 22, 24 and 29. For all other opcodes the enable is low and the destination is 0.
- R5: The implicit R0 write strobe is high only for multiply (4) and divide (5). These opcodes also assert the normal register write.
- R6: Memory read is high only for opcode 29 and memory write only for opcode 28. I/O read is high only for opcode 24 and I/O write only for opcode 25.
- R7: The branch class is set by opcode as follows:
  - 1 for opcode 16, 2 for opcode 17, 3 for opcode 18 and 4 for opcode 19.
  - 5 for opcode 20, 6 for opcode 22 and 7 for opcode 23.
  - 0 for all other opcodes.
- R8: The system flags rise only for their own opcode: halt for 31, reset for 30, interrupt for 26 and interrupt return for 27. At most one of them is high at a time.
- R9: None of the 32 opcode values is reported illegal. When the illegal output is high, every write strobe is low.
- R10: The ALU operation code is set by opcode as follows:
  - 1 (add) for opcodes 0, 1, 28 and 29; 2 (subtract) for opcodes 2 and 3.
  - 3 for opcode 4 and 4 for opcode 5.
  - 5 (and) for opcodes 8 and 9; 6 (or) for opcodes 10 and 11.
  - 7 for opcode 12, 8 for opcode 13, 9 for opcode 15, 10 for opcode 14, 11 for opcode 6 and 12 for opcode 7.
  - 0 for all other opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word to decode |
| opcode | output | 5 | Opcode field |
| fmtCode | output | 2 | Layout class 0..3 |
| raIdx | output | 3 | First register index |
| rbIdx | output | 3 | Second register index |
| rcIdx | output | 3 | Third register index |
| immVal | output | 16 | Extended constant |
| aluOp | output | 4 | ALU operation code |
| regWe | output | 1 | Register write enable |
| regDst | output | 3 | Register write destination |
| r0AuxWe | output | 1 | Implicit R0 write for multiply/divide |
| memRd | output | 1 | Memory read |
| memWr | output | 1 | Memory write |
| ioRd | output | 1 | I/O read |
| ioWr | output | 1 | I/O write |
| brClass | output | 3 | Branch or jump class |
| haltFlag | output | 1 | Halt instruction |
| resetFlag | output | 1 | Reset instruction |
| intFlag | output | 1 | Software interrupt instruction |
| iretFlag | output | 1 | Interrupt return instruction |
| illegal | output | 1 | Opcode not defined |

## Verification
Two functions can be active for the same word: the ordinary register write and the implicit R0 write of multiply and divide. The branch class and the link-register write of the call opcode can also be active together. These cases are provoked by decoding multiply, divide and call words. Each result is judged by checking both strobes and the destination index against the expected values. Neighbouring opcodes such as add and return are also decoded, to show that only one of the pair rises for them.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int OP_BITS = 5;

  typedef enum logic [1:0] {FMT_NONE = 2'd0, FMT_RI = 2'd1, FMT_RRI = 2'd2, FMT_RRR = 2'd3} fmt_e;

  typedef enum logic [2:0] {
    IMM_ZERO, IMM_SEXT8, IMM_ZEXT8, IMM_SEXT5, IMM_ZEXT5
  } imm_e;

  typedef enum logic [3:0] {
    ALU_NONE = 4'd0, ALU_ADD = 4'd1, ALU_SUB = 4'd2, ALU_MUL = 4'd3, ALU_DIV = 4'd4,
    ALU_AND = 4'd5, ALU_OR = 4'd6, ALU_SHL = 4'd7, ALU_SHR = 4'd8, ALU_ASR = 4'd9,
    ALU_NOT = 4'd10, ALU_PASS = 4'd11, ALU_IMM = 4'd12
  } alu_e;

  typedef enum logic [2:0] {
    BR_NONE = 3'd0, BR_POS = 3'd1, BR_NEG = 3'd2, BR_NZ = 3'd3, BR_Z = 3'd4,
    BR_ALWAYS = 3'd5, BR_CALL = 3'd6, BR_RET = 3'd7
  } br_e;

  // strobes from the control half to the field datapath
  typedef struct packed {
    fmt_e fmt;
    imm_e immSel;
  } fieldStrb_t;

  localparam logic [OP_BITS-1:0] OP_ADD = 5'd0,  OP_ADDI = 5'd1,  OP_SUB = 5'd2,  OP_SUBI = 5'd3;
  localparam logic [OP_BITS-1:0] OP_MUL = 5'd4,  OP_DIV = 5'd5,   OP_MOV = 5'd6,  OP_MOVI = 5'd7;
  localparam logic [OP_BITS-1:0] OP_AND = 5'd8,  OP_ANDI = 5'd9,  OP_OR = 5'd10,  OP_ORI = 5'd11;
  localparam logic [OP_BITS-1:0] OP_SHL = 5'd12, OP_SHR = 5'd13,  OP_NOT = 5'd14, OP_ASR = 5'd15;
  localparam logic [OP_BITS-1:0] OP_JPOS = 5'd16, OP_JNEG = 5'd17, OP_JNZ = 5'd18, OP_JZ = 5'd19;
  localparam logic [OP_BITS-1:0] OP_JMP = 5'd20, OP_NOP = 5'd21,  OP_CALL = 5'd22, OP_RET = 5'd23;
  localparam logic [OP_BITS-1:0] OP_IN = 5'd24,  OP_OUT = 5'd25,  OP_INT = 5'd26, OP_IRET = 5'd27;
  localparam logic [OP_BITS-1:0] OP_ST = 5'd28,  OP_LD = 5'd29,   OP_RST = 5'd30, OP_HALT = 5'd31;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int REG_W  = 3,
  parameter int C2_W   = 8,
  parameter int C1_W   = 5
) (
  input  logic [WORD_W-1:0] instr,
  input  fieldStrb_t        strb,
  output logic [REG_W-1:0]  raIdx,
  output logic [REG_W-1:0]  rbIdx,
  output logic [REG_W-1:0]  rcIdx,
  output logic [WORD_W-1:0] immVal
);
  localparam int RA_LSB = WORD_W - OP_BITS - REG_W;
  localparam int RB_LSB = RA_LSB - REG_W;
  localparam int RC_LSB = RB_LSB - REG_W;

  logic [C2_W-1:0] c2;
  logic [C1_W-1:0] c1;

  assign c2 = instr[C2_W-1:0];
  assign c1 = instr[C1_W-1:0];

  always_comb begin
    raIdx = (strb.fmt != FMT_NONE) ? instr[RA_LSB +: REG_W] : '0;
    rbIdx = (strb.fmt == FMT_RRI || strb.fmt == FMT_RRR) ? instr[RB_LSB +: REG_W] : '0;
    rcIdx = (strb.fmt == FMT_RRR) ? instr[RC_LSB +: REG_W] : '0;
  end

  always_comb begin
    case (strb.immSel)
      IMM_SEXT8: immVal = {{(WORD_W-C2_W){c2[C2_W-1]}}, c2};
      IMM_ZEXT8: immVal = {{(WORD_W-C2_W){1'b0}}, c2};
      IMM_SEXT5: immVal = {{(WORD_W-C1_W){c1[C1_W-1]}}, c1};
      IMM_ZEXT5: immVal = {{(WORD_W-C1_W){1'b0}}, c1};
      default:   immVal = '0;
    endcase
  end
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic [OP_BITS-1:0] opcode,
  input  logic [REG_W-1:0]   raField,
  output fieldStrb_t         strb,
  output logic [3:0]         aluOp,
  output logic               regWe,
  output logic [REG_W-1:0]   regDst,
  output logic               r0AuxWe,
  output logic               memRd,
  output logic               memWr,
  output logic               ioRd,
  output logic               ioWr,
  output logic [2:0]         brClass,
  output logic               haltFlag,
  output logic               resetFlag,
  output logic               intFlag,
  output logic               iretFlag,
  output logic               illegal
);
  alu_e aluSel;
  br_e  brSel;
  logic weRaw, auxRaw, mwRaw, iwRaw;

  always_comb begin
    strb.fmt    = FMT_NONE;
    strb.immSel = IMM_ZERO;
    aluSel = ALU_NONE;
    brSel  = BR_NONE;
    weRaw  = 1'b0;
    auxRaw = 1'b0;
    memRd  = 1'b0;
    mwRaw  = 1'b0;
    ioRd   = 1'b0;
    iwRaw  = 1'b0;
    haltFlag = 1'b0; resetFlag = 1'b0; intFlag = 1'b0; iretFlag = 1'b0;
    illegal = 1'b0;
    case (opcode)
      OP_ADD:  begin strb.fmt = FMT_RRR; aluSel = ALU_ADD; weRaw = 1'b1; end
      OP_SUB:  begin strb.fmt = FMT_RRR; aluSel = ALU_SUB; weRaw = 1'b1; end
      OP_MUL:  begin strb.fmt = FMT_RRR; aluSel = ALU_MUL; weRaw = 1'b1; auxRaw = 1'b1; end
      OP_DIV:  begin strb.fmt = FMT_RRR; aluSel = ALU_DIV; weRaw = 1'b1; auxRaw = 1'b1; end
      OP_AND:  begin strb.fmt = FMT_RRR; aluSel = ALU_AND; weRaw = 1'b1; end
      OP_OR:   begin strb.fmt = FMT_RRR; aluSel = ALU_OR;  weRaw = 1'b1; end
      OP_ADDI: begin strb.fmt = FMT_RRI; strb.immSel = IMM_SEXT5; aluSel = ALU_ADD; weRaw = 1'b1; end
      OP_SUBI: begin strb.fmt = FMT_RRI; strb.immSel = IMM_SEXT5; aluSel = ALU_SUB; weRaw = 1'b1; end
      OP_ANDI: begin strb.fmt = FMT_RRI; strb.immSel = IMM_ZEXT5; aluSel = ALU_AND; weRaw = 1'b1; end
      OP_ORI:  begin strb.fmt = FMT_RRI; strb.immSel = IMM_ZEXT5; aluSel = ALU_OR;  weRaw = 1'b1; end
      OP_SHL:  begin strb.fmt = FMT_RRI; strb.immSel = IMM_ZEXT5; aluSel = ALU_SHL; weRaw = 1'b1; end
      OP_SHR:  begin strb.fmt = FMT_RRI; strb.immSel = IMM_ZEXT5; aluSel = ALU_SHR; weRaw = 1'b1; end
      OP_ASR:  begin strb.fmt = FMT_RRI; strb.immSel = IMM_ZEXT5; aluSel = ALU_ASR; weRaw = 1'b1; end
      OP_LD:   begin strb.fmt = FMT_RRI; strb.immSel = IMM_SEXT5; aluSel = ALU_ADD; weRaw = 1'b1; memRd = 1'b1; end
      OP_ST:   begin strb.fmt = FMT_RRI; strb.immSel = IMM_SEXT5; aluSel = ALU_ADD; mwRaw = 1'b1; end
      OP_MOV:  begin strb.fmt = FMT_RRI; aluSel = ALU_PASS; weRaw = 1'b1; end
      OP_NOT:  begin strb.fmt = FMT_RRI; aluSel = ALU_NOT;  weRaw = 1'b1; end
      OP_CALL: begin strb.fmt = FMT_RRI; brSel = BR_CALL;   weRaw = 1'b1; end
      OP_MOVI: begin strb.fmt = FMT_RI; strb.immSel = IMM_SEXT8; aluSel = ALU_IMM; weRaw = 1'b1; end
      OP_IN:   begin strb.fmt = FMT_RI; strb.immSel = IMM_ZEXT8; weRaw = 1'b1; ioRd = 1'b1; end
      OP_OUT:  begin strb.fmt = FMT_RI; strb.immSel = IMM_ZEXT8; iwRaw = 1'b1; end
      OP_RET:  begin strb.fmt = FMT_RI; brSel = BR_RET; end
      OP_JPOS: begin strb.fmt = FMT_RI; strb.immSel = IMM_SEXT8; brSel = BR_POS; end
      OP_JNEG: begin strb.fmt = FMT_RI; strb.immSel = IMM_SEXT8; brSel = BR_NEG; end
      OP_JNZ:  begin strb.fmt = FMT_RI; strb.immSel = IMM_SEXT8; brSel = BR_NZ; end
      OP_JZ:   begin strb.fmt = FMT_RI; strb.immSel = IMM_SEXT8; brSel = BR_Z; end
      OP_JMP:  begin strb.fmt = FMT_RI; strb.immSel = IMM_SEXT8; brSel = BR_ALWAYS; end
      OP_NOP:  ;
      OP_INT:  intFlag = 1'b1;
      OP_IRET: iretFlag = 1'b1;
      OP_RST:  resetFlag = 1'b1;
      OP_HALT: haltFlag = 1'b1;
      default: illegal = 1'b1;
    endcase
  end

  // an undefined opcode must never touch architectural state
  assign regWe   = weRaw & ~illegal;
  assign r0AuxWe = auxRaw & ~illegal;
  assign memWr   = mwRaw & ~illegal;
  assign ioWr    = iwRaw & ~illegal;
  assign regDst  = regWe ? raField : '0;
  assign aluOp   = aluSel;
  assign brClass = brSel;
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int REG_W  = 3,
  parameter int C2_W   = 8,
  parameter int C1_W   = 5
) (
  input  logic [WORD_W-1:0]  instr,
  output logic [OP_BITS-1:0] opcode,
  output logic [1:0]         fmtCode,
  output logic [REG_W-1:0]   raIdx,
  output logic [REG_W-1:0]   rbIdx,
  output logic [REG_W-1:0]   rcIdx,
  output logic [WORD_W-1:0]  immVal,
  output logic [3:0]         aluOp,
  output logic               regWe,
  output logic [REG_W-1:0]   regDst,
  output logic               r0AuxWe,
  output logic               memRd,
  output logic               memWr,
  output logic               ioRd,
  output logic               ioWr,
  output logic [2:0]         brClass,
  output logic               haltFlag,
  output logic               resetFlag,
  output logic               intFlag,
  output logic               iretFlag,
  output logic               illegal
);
  localparam int OP_LSB = WORD_W - OP_BITS;
  localparam int RA_LSB = OP_LSB - REG_W;

  fieldStrb_t strb;

  assign opcode  = instr[OP_LSB +: OP_BITS];
  assign fmtCode = strb.fmt;

  idec_ctrl #(.REG_W(REG_W)) ctrl_i (
    .opcode(opcode), .raField(instr[RA_LSB +: REG_W]), .strb(strb),
    .aluOp(aluOp), .regWe(regWe), .regDst(regDst), .r0AuxWe(r0AuxWe),
    .memRd(memRd), .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr), .brClass(brClass),
    .haltFlag(haltFlag), .resetFlag(resetFlag), .intFlag(intFlag),
    .iretFlag(iretFlag), .illegal(illegal)
  );

  idec_fields #(.WORD_W(WORD_W), .REG_W(REG_W), .C2_W(C2_W), .C1_W(C1_W)) fields_i (
    .instr(instr), .strb(strb), .raIdx(raIdx), .rbIdx(rbIdx), .rcIdx(rcIdx),
    .immVal(immVal)
  );
endmodule

// File: rtl/idec_checker.sv
module idec_checker #(
  parameter int REG_W = 3
) (
  input logic [1:0]       fmtCode,
  input logic [REG_W-1:0] rcIdx,
  input logic [REG_W-1:0] rbIdx,
  input logic             regWe,
  input logic [REG_W-1:0] regDst,
  input logic             r0AuxWe,
  input logic             memRd,
  input logic             memWr,
  input logic             ioRd,
  input logic             ioWr,
  input logic [2:0]       brClass,
  input logic             haltFlag,
  input logic             resetFlag,
  input logic             intFlag,
  input logic             iretFlag,
  input logic             illegal
);
  always_comb begin
    assert_absent_regs_R1: assert ((fmtCode == 2'd3 || rcIdx == '0) &&
                                   (fmtCode >= 2'd2 || rbIdx == '0))
      else $error("register index driven for a layout without it");
    assert_dst_idle_R4: assert (regWe || regDst == '0)
      else $error("destination set without write");
    assert_aux_needs_main_R5: assert (!r0AuxWe || (regWe && fmtCode == 2'd3))
      else $error("R0 side write outside multiply/divide shape");
    assert_mem_excl_R6: assert (!(memRd && memWr) && !(ioRd && ioWr) &&
                                !((memRd || memWr) && (ioRd || ioWr)))
      else $error("conflicting memory/io strobes");
    assert_mem_layout_R6: assert (!(memRd || memWr) || fmtCode == 2'd2)
      else $error("memory access outside two-register layout");
    assert_branch_no_mem_R7: assert (brClass == 3'd0 || !(memRd || memWr || ioRd || ioWr))
      else $error("branch with data access");
    assert_sys_onehot_R8: assert ($onehot0({haltFlag, resetFlag, intFlag, iretFlag}) &&
      (!(haltFlag || resetFlag || intFlag || iretFlag) || (fmtCode == 2'd0 && !regWe)))
      else $error("system flags inconsistent");
    assert_illegal_quiet_R9: assert (!illegal || !(regWe || r0AuxWe || memWr || ioWr))
      else $error("illegal opcode with a write");
  end
endmodule

bind instr_decoder idec_checker #(.REG_W(REG_W)) checker_i (
  .fmtCode(fmtCode), .rcIdx(rcIdx), .rbIdx(rbIdx), .regWe(regWe), .regDst(regDst),
  .r0AuxWe(r0AuxWe), .memRd(memRd), .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr),
  .brClass(brClass), .haltFlag(haltFlag), .resetFlag(resetFlag), .intFlag(intFlag),
  .iretFlag(iretFlag), .illegal(illegal)
);

// File: tb/instr_decoder_tb_top.sv
module instr_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] instr = 16'hA800;
  logic [4:0]  opcode;
  logic [1:0]  fmtCode;
  logic [2:0]  raIdx, rbIdx, rcIdx, regDst, brClass;
  logic [15:0] immVal;
  logic [3:0]  aluOp;
  logic regWe, r0AuxWe, memRd, memWr, ioRd, ioWr;
  logic haltFlag, resetFlag, intFlag, iretFlag, illegal;
  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  instr_decoder dut_i (
    .instr(instr), .opcode(opcode), .fmtCode(fmtCode), .raIdx(raIdx), .rbIdx(rbIdx),
    .rcIdx(rcIdx), .immVal(immVal), .aluOp(aluOp), .regWe(regWe), .regDst(regDst),
    .r0AuxWe(r0AuxWe), .memRd(memRd), .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr),
    .brClass(brClass), .haltFlag(haltFlag), .resetFlag(resetFlag), .intFlag(intFlag),
    .iretFlag(iretFlag), .illegal(illegal)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk);
    instr = w;
    #2;
  endtask

  function automatic int expFmt(input int op);
    case (op)
      21, 26, 27, 30, 31: return 0;
      7, 16, 17, 18, 19, 20, 23, 24, 25: return 1;
      0, 2, 4, 5, 8, 10: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic test_idle;
    apply(16'hA800);
    check("R4", "nop regWe", int'(regWe), 0);
    check("R9", "nop illegal", int'(illegal), 0);
    check("R7", "nop brClass", int'(brClass), 0);
    check("R8", "nop flags", int'({haltFlag, resetFlag, intFlag, iretFlag}), 0);
    rst = 1'b0;
  endtask

  task automatic test_reference;
    apply(16'h3902);
    check("R1", "movi ra", int'(raIdx), 1);
    check("R3", "movi imm", int'(immVal), 2);
    check("R4", "movi dst", int'({regWe, regDst}), 9);
    apply(16'h014C);
    check("R1", "add opcode", int'(opcode), 0);
    check("R1", "add ra/rb/rc", int'({raIdx, rbIdx, rcIdx}), (1 << 6) | (2 << 3) | 3);
    check("R2", "add fmt", int'(fmtCode), 3);
    apply(16'hEAA6);
    check("R1", "load ra/rb", int'({raIdx, rbIdx}), (2 << 3) | 5);
    check("R3", "load imm", int'(immVal), 6);
    check("R6", "load memRd", int'({memRd, memWr}), 2);
    check("R4", "load dst", int'({regWe, regDst}), 10);
    apply(16'h9803);
    check("R7", "jz class", int'(brClass), 4);
    check("R3", "jz imm", int'(immVal), 3);
    check("R4", "jz regWe", int'(regWe), 0);
  endtask

  task automatic test_absent_fields;
    apply(16'hAFFF);
    check("R1", "nop fields zero", int'({raIdx, rbIdx, rcIdx}), 0);
    check("R3", "nop imm zero", int'(immVal), 0);
    apply(16'h3FFF);
    check("R1", "movi rb/rc zero", int'({rbIdx, rcIdx}), 0);
    check("R1", "movi ra", int'(raIdx), 7);
    apply(16'h37FF);
    check("R1", "mov rc zero", int'(rcIdx), 0);
    check("R3", "mov imm zero", int'(immVal), 0);
  endtask

  task automatic test_imm_ext;
    apply(16'hA080);
    check("R3", "jump c2 sext", int'(immVal), 16'hFF80);
    apply(16'h095F);
    check("R3", "addi c1 sext", int'(immVal), 16'hFFFF);
    apply(16'h647F);
    check("R3", "shiftl c1 zext", int'(immVal), 16'h001F);
    apply(16'h4930);
    check("R3", "andi c1 zext", int'(immVal), 16'h0010);
    apply(16'hC3C8);
    check("R3", "in c2 zext", int'(immVal), 16'h00C8);
    apply(16'h3880);
    check("R3", "movi c2 sext", int'(immVal), 16'hFF80);
  endtask

  task automatic test_mul_div;
    apply(16'h25E4);
    check("R5", "mul aux", int'(r0AuxWe), 1);
    check("R5", "mul main dst", int'({regWe, regDst}), 13);
    apply(16'h2CE8);
    check("R5", "div aux", int'(r0AuxWe), 1);
    check("R5", "div main dst", int'({regWe, regDst}), 12);
    apply(16'h014C);
    check("R5", "add no aux", int'(r0AuxWe), 0);
  endtask

  task automatic test_mem_io;
    apply(16'hE428);
    check("R6", "store mem", int'({memRd, memWr}), 1);
    check("R4", "store no write", int'({regWe, regDst}), 0);
    check("R3", "store imm", int'(immVal), 8);
    apply(16'hC3C8);
    check("R6", "in io", int'({ioRd, ioWr, memRd, memWr}), 8);
    check("R4", "in dst", int'({regWe, regDst}), 11);
    apply(16'hCF22);
    check("R6", "out io", int'({ioRd, ioWr}), 1);
    check("R4", "out no write", int'(regWe), 0);
  endtask

  task automatic test_branch;
    logic [15:0] words [5] = '{16'h8000, 16'h8800, 16'h9000, 16'h9800, 16'hA000};
    for (int i = 0; i < 5; i++) begin
      apply(words[i]);
      check("R7", "conditional/jump class", int'(brClass), i + 1);
    end
    apply(16'hB460);
    check("R7", "call class", int'(brClass), 6);
    check("R4", "call link dst", int'({regWe, regDst}), 12);
    check("R1", "call rb", int'(rbIdx), 3);
    apply(16'hBB00);
    check("R7", "ret class", int'(brClass), 7);
    check("R4", "ret no write", int'(regWe), 0);
  endtask

  task automatic test_sys;
    apply(16'hF800);
    check("R8", "halt", int'({haltFlag, resetFlag, intFlag, iretFlag}), 8);
    apply(16'hF000);
    check("R8", "reset", int'({haltFlag, resetFlag, intFlag, iretFlag}), 4);
    apply(16'hD000);
    check("R8", "int", int'({haltFlag, resetFlag, intFlag, iretFlag}), 2);
    apply(16'hD800);
    check("R8", "iret", int'({haltFlag, resetFlag, intFlag, iretFlag}), 1);
  endtask

  task automatic test_all_opcodes;
    for (int op = 0; op < 32; op++) begin
      apply(16'(op << 11));
      check("R9", $sformatf("illegal op %0d", op), int'(illegal), 0);
      check("R2", $sformatf("fmt op %0d", op), int'(fmtCode), expFmt(op));
    end
  endtask

  task automatic test_alu;
    logic [4:0] ops [15] = '{0, 2, 4, 5, 8, 10, 12, 13, 15, 14, 6, 7, 1, 29, 19};
    int exps [15] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 1, 1, 0};
    for (int i = 0; i < 15; i++) begin
      apply({ops[i], 11'd0});
      check("R10", $sformatf("aluOp for op %0d", ops[i]), int'(aluOp), exps[i]);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    test_idle();
    test_reference();
    test_absent_fields();
    test_imm_ext();
    test_mul_div();
    test_mem_io();
    test_branch();
    test_sys();
    test_all_opcodes();
    test_alu();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule